// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests from five peripherals (vertical blank, LCD status, timer, serial link and joypad) and presents one of them to the CPU as a handler address. Each peripheral raises a single-cycle request pulse. The pulse latches a bit in a request-flag register. An enable register selects which flags may interrupt. A master-enable flag, which the CPU sets and clears with two strobes, gates whether an interrupt is actually taken.

The CPU sees a pending line and a 16-bit handler vector for the highest-priority source that is both flagged and enabled. Lower bit numbers win. The vectors are fixed and spaced 8 bytes apart. When the CPU accepts the interrupt, it pulses an acknowledge. The acknowledge clears the serviced flag and the master-enable flag. Pushing the program counter is the CPU's job and is not part of this block. A separate wake output lets a halted CPU resume whenever an enabled flag is set, even while the master enable is clear. The CPU reads and writes both registers through a small address/data port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the flag register is 0, so it reads 0xE0. The enable register and the master enable are 0, and `irqPending` and `wake` are low.
- R2: A one-cycle pulse on `srcReq[i]` sets flag bit i at the next clock edge. The bits are: 0 vertical blank, 1 LCD status, 2 timer, 3 serial, 4 joypad. A set bit stays set until it is written or acknowledged.
- R3: The flag register sits at address 0xFF0F. A write replaces bits 4..0. Reads return bits 7..5 as 1. A request pulse in the same cycle as a write also sets its bit, on top of the written value.
- R4: The enable register sits at address 0xFFFF. All 8 bits read back as written, and only bits 4..0 take part in interrupt selection.
- R5: `irqPending` is high exactly when the master enable is set and at least one bit of (flags AND enables[4:0]) is set.
- R6: `irqVector` equals 0x0040 + 8*i, where i is the lowest set bit of (flags AND enables[4:0]). This gives 0x0040, 0x0048, 0x0050, 0x0058 and 0x0060 for bits 0 to 4.
- R7: An `irqAck` pulse clears the flag bit of the source selected in that cycle and clears the master enable. All other flag bits are left unchanged. A request on that same bit in the same cycle keeps the bit set.
- R8: `wake` is high exactly when (flags AND enables[4:0]) is non-zero, whatever the master enable holds.
- R9: `meSet` sets the master enable and `meClr` clears it. If both are high, the clear wins. If `meSet` and `irqAck` are high together, the master enable ends cleared.
- R10: A write to any address other than 0xFF0F or 0xFFFF changes no state. A read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 5 | Single-cycle request pulses, one per source |
| busAddr | input | 16 | CPU register address |
| busWr | input | 1 | CPU write strobe |
| busWrData | input | 8 | CPU write data |
| busRdData | output | 8 | CPU read data (combinational from `busAddr`) |
| meSet | input | 1 | Set master enable |
| meClr | input | 1 | Clear master enable |
| irqAck | input | 1 | CPU accepts the presented interrupt |
| irqPending | output | 1 | Interrupt ready to be taken |
| irqVector | output | 16 | Handler address of the selected source |
| wake | output | 1 | Resume request for a halted CPU |

## Verification
The bench first drives every flag and enable pattern, then acknowledges. This exposes a priority encoder that picks the highest bit instead of the lowest, since such a design would present the wrong vector and clear the wrong flag. Collisions come next: a request on the same bit as an acknowledge, a request during a flag write, and `meSet` together with `meClr` or with `irqAck`. A design that ordered any of these wrongly would lose a request or leave the master enable set. The bench also checks `wake` while the master enable is clear, because gating it by the master enable would leave a halted CPU asleep. Writes to a neighbouring address are checked too, since a loose address decode would corrupt the registers.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int DW      = 8;
  localparam int AW      = 16;

  typedef struct packed {
    logic               wrFlags;
    logic               wrEnable;
    logic               rdFlags;
    logic               rdEnable;
    logic               meOn;
    logic               meOff;
    logic [NUM_SRC-1:0] clrMask;
  } irqStrobes_t;
endpackage

// File: rtl/vec_irq_ctl.sv
module vec_irq_ctl
  import vec_irq_pkg::*;
#(
  parameter logic [AW-1:0] FLAG_ADDR  = 16'hFF0F,
  parameter logic [AW-1:0] EN_ADDR    = 16'hFFFF,
  parameter logic [AW-1:0] VEC_BASE   = 16'h0040,
  parameter int            VEC_STRIDE = 8
) (
  input  logic [AW-1:0]      busAddr,
  input  logic               busWr,
  input  logic               meSet,
  input  logic               meClr,
  input  logic               irqAck,
  input  logic [NUM_SRC-1:0] activeVec,
  input  logic               meQ,
  output irqStrobes_t        strobes,
  output logic               irqPending,
  output logic [AW-1:0]      irqVector,
  output logic               wake
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [IDX_W-1:0]   selIdx;
  logic               anyActive;
  logic [NUM_SRC-1:0] selMask;

  // lowest bit number wins: scan downward so the last hit is the lowest
  always_comb begin
    selIdx  = '0;
    selMask = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (activeVec[i]) begin
        selIdx  = IDX_W'(i);
        selMask = NUM_SRC'(1) << i;
      end
    end
  end

  assign anyActive  = |activeVec;
  assign wake       = anyActive;
  assign irqPending = anyActive & meQ;
  assign irqVector  = VEC_BASE + AW'(selIdx) * AW'(VEC_STRIDE);

  always_comb begin
    strobes          = '0;
    strobes.rdFlags  = (busAddr == FLAG_ADDR);
    strobes.rdEnable = (busAddr == EN_ADDR);
    strobes.wrFlags  = busWr & strobes.rdFlags;
    strobes.wrEnable = busWr & strobes.rdEnable;
    strobes.meOn     = meSet;
    strobes.meOff    = meClr | irqAck;
    strobes.clrMask  = irqAck ? selMask : '0;
  end
endmodule

// File: rtl/vec_irq_dp.sv
module vec_irq_dp
  import vec_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [DW-1:0]      busWrData,
  output logic [DW-1:0]      busRdData,
  output logic [NUM_SRC-1:0] activeVec,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [DW-1:0]      enQ,
  output logic               meQ
);
  localparam int PAD_W = DW - NUM_SRC;

  logic [NUM_SRC-1:0] flagBase;

  assign flagBase = strobes.wrFlags ? busWrData[NUM_SRC-1:0] : flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      meQ   <= 1'b0;
    end else begin
      flagQ <= (flagBase & ~strobes.clrMask) | srcReq;
      if (strobes.wrEnable) enQ <= busWrData;
      if (strobes.meOff)     meQ <= 1'b0;
      else if (strobes.meOn) meQ <= 1'b1;
    end
  end

  assign activeVec = flagQ & enQ[NUM_SRC-1:0];

  always_comb begin
    if (strobes.rdFlags)       busRdData = {{PAD_W{1'b1}}, flagQ};
    else if (strobes.rdEnable) busRdData = enQ;
    else                       busRdData = '0;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [AW-1:0]      busAddr,
  input  logic               busWr,
  input  logic [DW-1:0]      busWrData,
  output logic [DW-1:0]      busRdData,
  input  logic               meSet,
  input  logic               meClr,
  input  logic               irqAck,
  output logic               irqPending,
  output logic [AW-1:0]      irqVector,
  output logic               wake
);
  irqStrobes_t        strobes;
  logic [NUM_SRC-1:0] activeVec;
  logic [NUM_SRC-1:0] flagQ;
  logic [DW-1:0]      enQ;
  logic               meQ;

  vec_irq_ctl u_ctl (
    .busAddr(busAddr), .busWr(busWr), .meSet(meSet), .meClr(meClr),
    .irqAck(irqAck), .activeVec(activeVec), .meQ(meQ), .strobes(strobes),
    .irqPending(irqPending), .irqVector(irqVector), .wake(wake)
  );

  vec_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcReq(srcReq),
    .busWrData(busWrData), .busRdData(busRdData), .activeVec(activeVec),
    .flagQ(flagQ), .enQ(enQ), .meQ(meQ)
  );
endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk
  import vec_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic               busWr,
  input logic               meSet,
  input logic               meClr,
  input logic               irqAck,
  input logic               irqPending,
  input logic [AW-1:0]      irqVector,
  input logic               wake,
  input logic [NUM_SRC-1:0] flagQ,
  input logic               meQ
);
  logic [AW-1:0] vecOff;
  assign vecOff = irqVector - 16'h0040;

  // R2
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|srcReq) |=> ((flagQ & $past(srcReq)) == $past(srcReq)));

  // R5
  pending_needs_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (wake && meQ));

  // R6
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (vecOff[2:0] == 3'd0 && vecOff <= 16'h0020));

  // R7
  ack_clears_me_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !meQ);

  // R7
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqPending && srcReq == '0 && !busWr)
      |=> !flagQ[$past(vecOff[5:3])]);

  // R9
  me_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (meSet && !meClr && !irqAck) |=> meQ);
endmodule

bind vec_irq_ctrl vec_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .busWr(busWr), .meSet(meSet),
  .meClr(meClr), .irqAck(irqAck), .irqPending(irqPending),
  .irqVector(irqVector), .wake(wake), .flagQ(flagQ), .meQ(meQ)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  srcReq;
  logic [15:0] busAddr;
  logic        busWr;
  logic [7:0]  busWrData;
  logic [7:0]  busRdData;
  logic        meSet, meClr, irqAck;
  logic        irqPending, wake;
  logic [15:0] irqVector;

  int checks = 0;
  int failures = 0;
  logic [4:0] mFlags;
  logic [7:0] mEn;
  logic       mMe;
  bit         done = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .meSet(meSet), .meClr(meClr),
    .irqAck(irqAck), .irqPending(irqPending), .irqVector(irqVector), .wake(wake)
  );

  function automatic logic [4:0] lowMask(input logic [4:0] v);
    return v & (~v + 5'd1);
  endfunction

  function automatic logic [15:0] expVec(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return 16'h0040 + 16'(i * 8);
    return 16'h0040;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic outChk();
    logic [4:0] a;
    a = mFlags & mEn[4:0];
    chk("R5 pending", 16'(irqPending), 16'(mMe && a != 0));
    chk("R8 wake", 16'(wake), 16'(a != 0));
    if (mMe && a != 0) chk("R6 vector", irqVector, expVec(a));
  endtask

  // one clock: drive at negedge, model the edge, check after it
  task automatic step(input logic [4:0] req, input logic wr, input logic [15:0] addr,
                      input logic [7:0] d, input logic set, input logic clr, input logic ack);
    logic [4:0] base, am;
    @(negedge clk);
    srcReq = req; busWr = wr; busAddr = addr; busWrData = d;
    meSet = set; meClr = clr; irqAck = ack;
    base = (wr && addr == 16'hFF0F) ? d[4:0] : mFlags;
    am = ack ? lowMask(mFlags & mEn[4:0]) : 5'd0;
    @(posedge clk);
    mFlags = (base & ~am) | req;
    if (wr && addr == 16'hFFFF) mEn = d;
    if (ack || clr) mMe = 1'b0; else if (set) mMe = 1'b1;
    #1;
    srcReq = '0; busWr = 0; meSet = 0; meClr = 0; irqAck = 0;
    outChk();
  endtask

  task automatic rdChk(input string tag, input logic [15:0] addr, input logic [7:0] exp);
    @(negedge clk);
    busAddr = addr;
    #1;
    chk(tag, 16'(busRdData), 16'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 0; srcReq = '0; busAddr = '0; busWr = 0; busWrData = '0;
    meSet = 0; meClr = 0; irqAck = 0;
    mFlags = '0; mEn = '0; mMe = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1 reset state
    chk("R1 pending", 16'(irqPending), 16'd0);
    chk("R1 wake", 16'(wake), 16'd0);
    rdChk("R1 flags", 16'hFF0F, 8'hE0);
    rdChk("R1 enable", 16'hFFFF, 8'h00);

    // R2 each source sets its bit; R8 wake with master enable clear
    step(5'b00000, 1, 16'hFFFF, 8'hFF, 0, 0, 0);
    rdChk("R4 enable readback", 16'hFFFF, 8'hFF);
    for (int i = 0; i < 5; i++) begin
      step(5'd1 << i, 0, 16'h0, 8'h0, 0, 0, 0);
      rdChk("R2 flag set", 16'hFF0F, {3'b111, mFlags});
    end
    chk("R8 wake without master", 16'(wake), 16'd1);

    // R6/R7 drain in priority order
    for (int i = 0; i < 5; i++) begin
      step(5'd0, 0, 16'h0, 8'h0, 1, 0, 0);
      chk("R6 priority vector", irqVector, 16'h0040 + 16'(i * 8));
      step(5'd0, 0, 16'h0, 8'h0, 0, 0, 1);
      rdChk("R7 ack clears one", 16'hFF0F, {3'b111, mFlags});
      chk("R7 master cleared", 16'(irqPending), 16'd0);
    end

    // R7 request on acked bit in same cycle survives
    step(5'b00100, 0, 16'h0, 8'h0, 1, 0, 0);
    step(5'b00100, 0, 16'h0, 8'h0, 0, 0, 1);
    rdChk("R7 ack vs request", 16'hFF0F, 8'hE4);

    // R3 write with simultaneous request
    step(5'b10000, 1, 16'hFF0F, 8'h03, 0, 0, 0);
    rdChk("R3 write plus request", 16'hFF0F, 8'hF3);

    // R9 collisions
    step(5'd0, 0, 16'h0, 8'h0, 1, 1, 0);
    chk("R9 clear wins", 16'(irqPending), 16'd0);
    step(5'd0, 0, 16'h0, 8'h0, 1, 0, 1);
    chk("R9 ack beats set", 16'(irqPending), 16'd0);

    // R10 neighbour address
    step(5'd0, 1, 16'hFF0E, 8'h00, 0, 0, 0);
    step(5'd0, 1, 16'hFFFE, 8'h00, 0, 0, 0);
    rdChk("R10 flags untouched", 16'hFF0F, {3'b111, mFlags});
    rdChk("R10 enable untouched", 16'hFFFF, mEn);
    rdChk("R10 other read", 16'hFF10, 8'h00);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [31:0] r;
      r = $urandom;
      case (r[1:0])
        2'd0: a = 16'hFF0F;
        2'd1: a = 16'hFFFF;
        default: a = 16'hFF0E;
      endcase
      step(($urandom % 4 == 0) ? 5'($urandom) : 5'd0, r[4:2] == 0, a, 8'($urandom),
           r[7:5] == 0, r[10:8] == 0, r[13:11] == 0);
      if (n % 16 == 0) begin
        rdChk("R2 flags random", 16'hFF0F, {3'b111, mFlags});
        rdChk("R4 enable random", 16'hFFFF, mEn);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule